// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses of one SDRAM read or write burst, one address per clock. A controller presents a starting column, a burst-length code and an ordering choice together with a one-cycle start pulse. From the following cycle the block issues the burst's columns with a valid flag, and it raises a final-beat flag on the closing beat.

Fixed-length bursts of 1, 2, 4 or 8 beats stay inside the aligned group of columns that holds the starting column. They use either linear wrap-around order or exclusive-OR order. A page-length burst walks every column of the row in linear order and wraps past the top column. It runs until a stop pulse ends it. A new start pulse always aborts the burst in progress and begins a fresh one.

Top module: `sdram_col_seq`

## Requirements
- R1: While reset is low, and after reset until the first start pulse, `col_valid` and `col_last` are 0. A reset in the middle of a burst ends it at once.
- R2: A start pulse sampled at a clock edge makes `col_valid` 1 from that edge on, with `col_addr` equal to the sampled `start_col` on the first beat.
- R3: `len_code` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a page-length burst. The reserved codes 4, 5 and 6 give a 1-beat burst.
- R4: In linear order (`ilv_order` = 0) with length L, beat i has the low log2(L) column bits equal to (start low bits + i) mod L. The upper bits stay equal to those of `start_col`.
- R5: In exclusive-OR order (`ilv_order` = 1) with length L of 2 to 8, beat i has the low log2(L) bits equal to the start low bits XOR i. The upper bits stay equal to those of `start_col`.
- R6: A page-length burst ignores `ilv_order` and always runs in linear order.
- R7: A page-length burst adds one to the column each cycle, wraps from column 2^COL_W-1 to column 0, and keeps running with no end of its own.
- R8: For a fixed length L, `col_last` is 1 on beat L-1 only, and `col_valid` falls on the next cycle unless a new start arrives.
- R9: During a page-length burst, `col_last` stays 0 while `stop` is low. When `stop` is high in a beat's cycle, `col_last` is 1 in that same cycle and no beat follows it.
- R10: `stop` has no effect during a fixed-length burst or while idle.
- R11: A start pulse during a burst, even with `stop` high in the same cycle, ends the old burst and begins the new one on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a burst |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Burst-length code (R3) |
| ilv_order | input | 1 | 0 for linear order, 1 for exclusive-OR order |
| stop | input | 1 | Ends a page-length burst |
| col_addr | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A beat is present this cycle |
| col_last | output | 1 | This beat is the final one |

## Verification
The assertions assume that `start` and `stop` are clean synchronous pulses. They also assume that the length code seen at a start is the length of the burst that follows, which the checker tracks from the start inputs alone. The stimulus changes every input only on falling clock edges. It holds `start` high for exactly one cycle, except in the deliberate restart case, so each burst's beats can be predicted from its own starting column, code and order. Stop pulses are placed in page-length bursts, in fixed bursts and in idle time to cover each case of the stop rule.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;

    localparam int LEN_CODE_W = 3;

    typedef enum logic [LEN_CODE_W-1:0] {
        LEN_ONE  = 3'd0,
        LEN_TWO  = 3'd1,
        LEN_FOUR = 3'd2,
        LEN_EIGHT = 3'd3,
        LEN_PAGE = 3'd7
    } len_code_e;

endpackage

// File: rtl/col_len_decode.sv
module col_len_decode
    import sdram_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [LEN_CODE_W-1:0] code,
    output logic [COL_W-1:0]      wrap_mask,
    output logic                  page_mode
);

    always_comb begin
        wrap_mask = '0;
        page_mode = 1'b0;
        case (code)
            LEN_TWO:   wrap_mask = COL_W'(1);
            LEN_FOUR:  wrap_mask = COL_W'(3);
            LEN_EIGHT: wrap_mask = COL_W'(7);
            LEN_PAGE: begin
                wrap_mask = '1;
                page_mode = 1'b1;
            end
            default:   wrap_mask = '0;
        endcase
    end

endmodule

// File: rtl/col_addr_mix.sv
module col_addr_mix #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] wrap_mask,
    input  logic             xor_order,
    output logic [COL_W-1:0] addr
);

    logic [COL_W-1:0] lin_sum;

    assign lin_sum = base + beat;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        logic low_val;
        assign low_val = xor_order ? (base[b] ^ beat[b]) : lin_sum[b];
        assign addr[b] = wrap_mask[b] ? low_val : base[b];
    end

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
    import sdram_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [COL_W-1:0]      start_col,
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  ilv_order,
    input  logic                  stop,
    output logic [COL_W-1:0]      col_addr,
    output logic                  col_valid,
    output logic                  col_last
);

    typedef struct packed {
        logic             active;
        logic             page;
        logic             xor_ord;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] addr;
        logic             last;
    } seq_t;

    seq_t st_d, st_q;

    logic [COL_W-1:0] new_mask;
    logic             new_page;
    logic [COL_W-1:0] beat_inc;
    logic [COL_W-1:0] next_addr;

    col_len_decode #(.COL_W(COL_W)) u_dec (
        .code      (len_code),
        .wrap_mask (new_mask),
        .page_mode (new_page)
    );

    assign beat_inc = st_q.beat + COL_W'(1);

    col_addr_mix #(.COL_W(COL_W)) u_mix (
        .base      (st_q.base),
        .beat      (beat_inc),
        .wrap_mask (st_q.mask),
        .xor_order (st_q.xor_ord),
        .addr      (next_addr)
    );

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.active  = 1'b1;
            st_d.page    = new_page;
            st_d.xor_ord = ilv_order & ~new_page;
            st_d.mask    = new_mask;
            st_d.base    = start_col;
            st_d.beat    = '0;
            st_d.addr    = start_col;
            st_d.last    = ~new_page & (new_mask == '0);
        end else if (st_q.active && st_q.page && stop) begin
            st_d.active = 1'b0;
            st_d.last   = 1'b0;
        end else if (st_q.active && !st_q.page && st_q.last) begin
            st_d.active = 1'b0;
            st_d.last   = 1'b0;
        end else if (st_q.active) begin
            st_d.beat = beat_inc;
            st_d.addr = next_addr;
            st_d.last = ~st_q.page & (beat_inc == st_q.mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_addr  = st_q.addr;
    assign col_valid = st_q.active;
    assign col_last  = st_q.active & (st_q.last | (st_q.page & stop));

endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk
    import sdram_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic [COL_W-1:0]      start_col,
    input logic [LEN_CODE_W-1:0] len_code,
    input logic                  stop,
    input logic [COL_W-1:0]      col_addr,
    input logic                  col_valid,
    input logic                  col_last
);

    logic fp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_q <= 1'b0;
        end else if (start) begin
            fp_q <= (len_code == LEN_PAGE);
        end
    end

    // R2
    start_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (col_valid && col_addr == $past(start_col)));

    // R8
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    // R8
    end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && col_last && !start) |=> !col_valid);

    // R9
    page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && fp_q && !stop) |-> !col_last);

    // R9
    page_stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && fp_q && stop && !start) |=> !col_valid);

    // R7
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && fp_q && !stop && !start) |=>
            (col_valid && col_addr == COL_W'($past(col_addr) + 1'b1)));

endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sdram_col_seq_test.sv
module sdram_col_seq_test;

    localparam int COL_W = 9;
    localparam int NCOL  = 1 << COL_W;
    localparam int NVEC  = 8;

    // entry: {start column, length code, order}
    localparam logic [COL_W+3:0] VEC [NVEC] = '{
        {9'd5,   3'd0, 1'b0},
        {9'd7,   3'd1, 1'b0},
        {9'd7,   3'd1, 1'b1},
        {9'd6,   3'd2, 1'b0},
        {9'd45,  3'd3, 1'b0},
        {9'd45,  3'd3, 1'b1},
        {9'd301, 3'd2, 1'b1},
        {9'd3,   3'd5, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [2:0]       len_code = '0;
    logic             ilv_order = 1'b0;
    logic             stop = 1'b0;
    logic [COL_W-1:0] col_addr;
    logic             col_valid;
    logic             col_last;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdram_col_seq #(.COL_W(COL_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_col (start_col),
        .len_code  (len_code),
        .ilv_order (ilv_order),
        .stop      (stop),
        .col_addr  (col_addr),
        .col_valid (col_valid),
        .col_last  (col_last)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int len_of(input int code);
        if (code <= 3) return 1 << code;
        if (code == 7) return NCOL;
        return 1;
    endfunction

    function automatic int exp_col(input int col, input int code, input int ord, input int i);
        int l = len_of(code);
        int low = col % l;
        int up = col - low;
        if (code == 7) return (col + i) % NCOL;
        if (ord != 0) return up + (low ^ i);
        return up + ((low + i) % l);
    endfunction

    task automatic begin_burst(input int col, input int code, input int ord);
        @(negedge clk);
        start = 1'b1;
        start_col = COL_W'(col);
        len_code = 3'(code);
        ilv_order = ord[0];
        @(negedge clk);
        start = 1'b0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(col_valid), 0);
        check("R1 last in reset", int'(col_last), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle after reset", int'(col_valid), 0);

        // R2 R3 R4 R5 R8: table walk
        for (int v = 0; v < NVEC; v++) begin
            int col = int'(VEC[v][COL_W+3:4]);
            int code = int'(VEC[v][3:1]);
            int ord = int'(VEC[v][0]);
            int l = len_of(code);
            begin_burst(col, code, ord);
            for (int i = 0; i < l; i++) begin
                check(ord != 0 ? "R5 valid" : "R4 valid", int'(col_valid), 1);
                check(ord != 0 ? "R5 addr" : "R4 addr", int'(col_addr),
                      exp_col(col, code, ord, i));
                check("R8 last flag", int'(col_last), (i == l - 1) ? 1 : 0);
                @(negedge clk);
            end
            check("R3 burst ends", int'(col_valid), 0);
        end

        // R6 R7 R9: page burst with xor order requested, wrap, then stop
        begin_burst(509, 7, 1);
        for (int i = 0; i < 6; i++) begin
            check("R7 page addr", int'(col_addr), (509 + i) % NCOL);
            check("R9 no last in page", int'(col_last), 0);
            check("R6 page valid", int'(col_valid), 1);
            @(negedge clk);
        end
        stop = 1'b1;
        #1;
        check("R9 last on stop", int'(col_last), 1);
        check("R9 beat at stop", int'(col_addr), 3);
        @(negedge clk);
        stop = 1'b0;
        check("R9 nothing after stop", int'(col_valid), 0);

        // R10: stop in a fixed burst is ignored
        begin_burst(20, 3, 0);
        for (int i = 0; i < 8; i++) begin
            stop = (i == 2 || i == 7);
            #1;
            check("R10 addr", int'(col_addr), exp_col(20, 3, 0, i));
            check("R10 last", int'(col_last), (i == 7) ? 1 : 0);
            @(negedge clk);
        end
        stop = 1'b0;
        check("R10 end", int'(col_valid), 0);
        // R10: stop while idle
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        @(negedge clk);
        check("R10 idle stop", int'(col_valid), 0);

        // R11: restart mid-burst with stop high
        begin_burst(0, 3, 0);
        @(negedge clk);
        @(negedge clk);
        start = 1'b1;
        stop = 1'b1;
        start_col = COL_W'(100);
        len_code = 3'd2;
        ilv_order = 1'b0;
        @(negedge clk);
        start = 1'b0;
        stop = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check("R11 new addr", int'(col_addr), 100 + i);
            check("R11 last", int'(col_last), (i == 3) ? 1 : 0);
            @(negedge clk);
        end
        check("R11 end", int'(col_valid), 0);

        // R1: reset mid-burst
        begin_burst(0, 7, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset aborts", int'(col_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stays idle", int'(col_valid), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule